// File: doc/BRIEF.md
# Protected Nonvolatile Data Memory Controller

This block sits on a small CPU register bus and fronts a byte-wide data store of 64 locations, held in flops. Software selects a location through an address register and moves bytes through a data register. A read is a single control-register write, and the byte lands in the data register one clock later.

Writes are guarded against runaway code. The CPU first arms a write-enable bit in one bus write. It then writes the two key bytes 0x55 and 0xAA to a write-only key register. Only after that may a later control write set the write-go bit. The write then runs for `WRITE_CYCLES` clocks, during which the address, the data and further requests are frozen. At the end the go bit drops, the byte is stored and a sticky done flag rises. The done flag is mirrored on a level output for an interrupt controller.

Top module: `guarded_dmem_ctrl`

## Requirements
- R1: After reset the address, data and control registers all read 0x00, and `done_irq` is 0.
- R2: Register selection uses `bus_addr`: 0 is the address register, 1 is the data register, 2 is control and 3 is the key register. The address register keeps `bus_wdata[5:0]` and reads back zero-extended. The key register always reads 0x00. Control reads back as {bit7 mem-select, bit4 done, bit2 write-enable, bit1 write-go}, and all other bits read 0.
- R3: A control write with bit 0 set and bit 7 clear loads the array byte at the address register into the data register, visible on the next cycle. With bit 7 set, that write leaves the data register unchanged.
- R4: The data register keeps its value until another read or a CPU write to register 1.
- R5: A write starts only after this sequence: 0x55 written to register 3, then 0xAA written to register 3, then a control write with bit 1 set. Each byte needs a fresh sequence.
- R6: Any bus access between the steps returns the sequence to its start. This covers a read or write of any register and a wrong key byte. Idle bus cycles have no effect, and writing 0x55 always begins a new sequence.
- R7: The write starts only if write-enable was already 1 before the go write and bit 7 of the go write is 0. Setting write-enable and write-go in the same write does not start a write.
- R8: After a start, write-go reads 1 for exactly `WRITE_CYCLES` cycles. It then clears, the array byte is updated and the done flag sets.
- R9: While write-go is 1, writes to the address and data registers and read or go requests are ignored.
- R10: Hardware never clears write-enable. Clearing it during a write does not abort the write.
- R11: The done flag stays set until a control write with bit 4 = 0 clears it. `done_irq` follows the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| done_irq | output | 1 | Level copy of the done flag |

## Verification
Every location is written through the full key sequence, first with an arithmetic pattern and then with its complement. Each value is read back, so address decoding and all data bits are separated from any stuck or aliased bit. Each write also measures the busy time against `WRITE_CYCLES`. A set of broken sequences follows: swapped keys, an interposed read, an interposed register write, enable and go in the same write, mem-select set, and a stale sequence reused. These tell apart the ordering rules from the enable rule. A positive case with idle gaps and a repeated 0x55 shows that only real accesses reset the sequence. Bus traffic during a running write, including clearing write-enable, separates frozen state from an aborted write.

// File: rtl/gdm_pkg.sv
package gdm_pkg;

  typedef enum logic [1:0] {
    REG_ADDR = 2'd0,
    REG_DATA = 2'd1,
    REG_CTRL = 2'd2,
    REG_KEY  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_FIRST = 2'd1,
    KS_ARMED = 2'd2
  } key_state_e;

  localparam int CB_RD   = 0;
  localparam int CB_GO   = 1;
  localparam int CB_WEN  = 2;
  localparam int CB_DONE = 4;
  localparam int CB_MSEL = 7;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  // next state of the key sequencer for one bus cycle
  function automatic key_state_e key_next(input key_state_e cur, input logic acc,
                                          input logic we, input reg_sel_e sel,
                                          input logic [7:0] wd);
    key_state_e nxt;
    if (!acc) nxt = cur;
    else if (we && sel == REG_KEY && wd == KEY_FIRST) nxt = KS_FIRST;
    else if (we && sel == REG_KEY && wd == KEY_SECOND && cur == KS_FIRST) nxt = KS_ARMED;
    else nxt = KS_IDLE;
    return nxt;
  endfunction

  // control register image as seen by a bus read
  function automatic logic [7:0] ctrl_image(input logic go, input logic wen,
                                            input logic done, input logic msel);
    logic [7:0] v;
    v = 8'h00;
    v[CB_GO]   = go;
    v[CB_WEN]  = wen;
    v[CB_DONE] = done;
    v[CB_MSEL] = msel;
    return v;
  endfunction

endpackage

// File: rtl/gdm_key_fsm.sv
module gdm_key_fsm
  import gdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       we,
  input  reg_sel_e   sel,
  input  logic [7:0] wd,
  output logic       armed
);

  key_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= key_next(state_q, acc, we, sel, wd);
  end

  assign armed = (state_q == KS_ARMED);

endmodule

// File: rtl/gdm_wr_timer.sv
module gdm_wr_timer #(
  parameter int WRITE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WRITE_CYCLES);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == ONE);

endmodule

// File: rtl/gdm_store.sv
module gdm_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/guarded_dmem_ctrl.sv
module guarded_dmem_ctrl
  import gdm_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int WRITE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       done_irq
);

  localparam int DATA_W = 8;
  localparam int PAD_W  = DATA_W - ADDR_W;

  reg_sel_e          rsel;
  logic              wr_acc;
  logic              ctl_wr;
  logic              rd_fire;
  logic              wr_start;
  logic              wr_done;
  logic              busy;
  logic              key_armed;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              wren_q;
  logic              msel_q;
  logic              flag_q;
  logic [DATA_W-1:0] mem_rdata;

  assign rsel    = reg_sel_e'(bus_addr);
  assign wr_acc  = bus_sel & bus_we;
  assign ctl_wr  = wr_acc && (rsel == REG_CTRL);
  assign rd_fire = ctl_wr && bus_wdata[CB_RD] && !bus_wdata[CB_MSEL] && !busy;
  assign wr_start = ctl_wr && bus_wdata[CB_GO] && !bus_wdata[CB_MSEL]
                    && wren_q && key_armed && !busy;

  gdm_key_fsm u_key (
    .clk   (clk),
    .rst_n (rst_n),
    .acc   (bus_sel),
    .we    (bus_we),
    .sel   (rsel),
    .wd    (bus_wdata),
    .armed (key_armed)
  );

  gdm_wr_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wr_start),
    .busy  (busy),
    .done  (wr_done)
  );

  gdm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (wr_done),
    .waddr (addr_q),
    .wdata (data_q),
    .raddr (addr_q),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (!busy) begin
      if (wr_acc && rsel == REG_ADDR) addr_q <= bus_wdata[ADDR_W-1:0];
      if (rd_fire)                              data_q <= mem_rdata;
      else if (wr_acc && rsel == REG_DATA)      data_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wren_q <= 1'b0;
      msel_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        wren_q <= bus_wdata[CB_WEN];
        msel_q <= bus_wdata[CB_MSEL];
      end
      if (wr_done)     flag_q <= 1'b1;
      else if (ctl_wr) flag_q <= flag_q & bus_wdata[CB_DONE];
    end
  end

  always_comb begin
    unique case (rsel)
      REG_ADDR: bus_rdata = {{PAD_W{1'b0}}, addr_q};
      REG_DATA: bus_rdata = data_q;
      REG_CTRL: bus_rdata = ctrl_image(busy, wren_q, flag_q, msel_q);
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign done_irq = flag_q;

endmodule

// File: rtl/gdm_checker.sv
module gdm_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              busy,
  input logic              key_armed,
  input logic              wren_q,
  input logic              flag_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [7:0]        data_q,
  input logic              wr_done
);

  logic ctl_w;
  assign ctl_w = bus_sel && bus_we && (bus_addr == 2'd2);

  a_r5_start_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(key_armed));

  a_r7_start_needs_wren: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(wren_q) && !$past(bus_wdata[7])));

  a_r8_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> (flag_q && !busy));

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(ctl_w && !bus_wdata[4])) |=> flag_q);

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(addr_q) && $stable(data_q)));

  a_r10_wren_hw: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wren_q) |-> $past(ctl_w && !bus_wdata[2]));

  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $past(bus_sel && bus_we && (bus_addr == 2'd1 || bus_addr == 2'd2)));

  a_r2_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 2'd3) |-> (bus_rdata == 8'h00));

endmodule

bind guarded_dmem_ctrl gdm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .busy      (busy),
  .key_armed (key_armed),
  .wren_q    (wren_q),
  .flag_q    (flag_q),
  .addr_q    (addr_q),
  .data_q    (data_q),
  .wr_done   (wr_done)
);

// File: tb/test_guarded_dmem_ctrl.sv
`timescale 1ns/1ps
module test_guarded_dmem_ctrl;

  localparam int WC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       done_irq;

  int vectors = 0;
  int fails = 0;
  logic [7:0] model [64];

  always #4 clk = ~clk;

  guarded_dmem_ctrl #(.ADDR_W(6), .WRITE_CYCLES(WC)) i_guarded_dmem_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done_irq(done_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic br(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_irq(output int k);
    k = 0;
    while (!done_irq && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  // enable already set, key sequence, go; returns busy length
  task automatic do_write(input logic [5:0] a, input logic [7:0] d, input string req);
    int k;
    bw(2'd0, {2'b00, a});
    bw(2'd1, d);
    bw(2'd2, 8'h04);
    bw(2'd3, 8'h55);
    bw(2'd3, 8'hAA);
    bw(2'd2, 8'h06);
    wait_irq(k);
    chk(req, 8'(k), 8'(WC));
    model[a] = d;
    bw(2'd2, 8'h04);
  endtask

  task automatic readback(input logic [5:0] a, input string req);
    logic [7:0] d;
    bw(2'd0, {2'b00, a});
    bw(2'd2, 8'h05);
    br(2'd1, d);
    chk(req, d, model[a]);
  endtask

  task automatic expect_no_start(input string req, input logic [7:0] ctrl_exp);
    logic [7:0] c;
    br(2'd2, c);
    chk(req, c, ctrl_exp);
    repeat (WC + 2) @(negedge clk);
    chk(req, {7'd0, done_irq}, 8'h00);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    br(2'd0, d); chk("R1 addr", d, 8'h00);
    br(2'd1, d); chk("R1 data", d, 8'h00);
    br(2'd2, d); chk("R1 ctrl", d, 8'h00);
    chk("R1 irq", {7'd0, done_irq}, 8'h00);

    // R2 register map
    bw(2'd0, 8'hFF); br(2'd0, d); chk("R2 addr width", d, 8'h3F);
    bw(2'd3, 8'h55); br(2'd3, d); chk("R2 key reads zero", d, 8'h00);
    bw(2'd1, 8'hC3); br(2'd1, d); chk("R2 data rw", d, 8'hC3);

    // R5 R8 sweep, two patterns, every location
    for (int a = 0; a < 64; a++) do_write(6'(a), 8'(a * 37 + 11), "R8 busy length");
    for (int a = 0; a < 64; a++) readback(6'(a), "R3 readback p1");
    for (int a = 0; a < 64; a++) do_write(6'(a), ~8'(a * 37 + 11), "R8 busy length");
    for (int a = 0; a < 64; a++) readback(6'(a), "R3 readback p2");

    // R5 swapped keys
    bw(2'd0, 8'd5); bw(2'd1, 8'h11);
    bw(2'd3, 8'hAA); bw(2'd3, 8'h55); bw(2'd2, 8'h06);
    expect_no_start("R5 swapped keys", 8'h04);
    readback(6'd5, "R5 swapped keys mem");

    // R6 interposed read
    bw(2'd0, 8'd6); bw(2'd1, 8'h22);
    bw(2'd3, 8'h55); br(2'd1, d); bw(2'd3, 8'hAA); bw(2'd2, 8'h06);
    expect_no_start("R6 interposed read", 8'h04);
    readback(6'd6, "R6 interposed read mem");

    // R6 interposed register write
    bw(2'd0, 8'd7); bw(2'd1, 8'h33);
    bw(2'd3, 8'h55); bw(2'd3, 8'hAA); bw(2'd0, 8'd7); bw(2'd2, 8'h06);
    expect_no_start("R6 interposed write", 8'h04);
    readback(6'd7, "R6 interposed write mem");

    // R7 enable and go in the same write
    bw(2'd2, 8'h00);
    bw(2'd0, 8'd8); bw(2'd1, 8'h44);
    bw(2'd3, 8'h55); bw(2'd3, 8'hAA); bw(2'd2, 8'h06);
    expect_no_start("R7 same write enable", 8'h04);
    readback(6'd8, "R7 same write mem");

    // R7 mem-select set in the go write
    bw(2'd0, 8'd9); bw(2'd1, 8'h55);
    bw(2'd3, 8'h55); bw(2'd3, 8'hAA); bw(2'd2, 8'h86);
    expect_no_start("R7 msel set", 8'h84);
    bw(2'd2, 8'h04);
    readback(6'd9, "R7 msel mem");

    // R5 stale sequence reused after a good write
    do_write(6'd12, 8'h5A, "R5 good write");
    bw(2'd1, 8'h77); bw(2'd2, 8'h06);
    expect_no_start("R5 reuse", 8'h04);
    readback(6'd12, "R5 reuse mem");

    // R6 idle gaps and repeated first key still start
    bw(2'd0, 8'd13); bw(2'd1, 8'hE1);
    bw(2'd3, 8'h55); repeat (5) @(negedge clk);
    bw(2'd3, 8'h55); bw(2'd3, 8'hAA); repeat (3) @(negedge clk);
    bw(2'd2, 8'h06);
    wait_irq(k); chk("R6 gaps start", 8'(k), 8'(WC));
    model[13] = 8'hE1;
    bw(2'd2, 8'h04);
    readback(6'd13, "R6 gaps mem");

    // R9 R10 traffic during a running write
    bw(2'd0, 8'd10); bw(2'd1, 8'h3C);
    bw(2'd3, 8'h55); bw(2'd3, 8'hAA); bw(2'd2, 8'h06);
    bw(2'd0, 8'd20); bw(2'd1, 8'h99); bw(2'd2, 8'h05); bw(2'd2, 8'h00);
    wait_irq(k);
    model[10] = 8'h3C;
    br(2'd0, d); chk("R9 addr frozen", d, 8'd10);
    br(2'd1, d); chk("R9 data frozen", d, 8'h3C);
    br(2'd2, d); chk("R10 write completes, enable stays clear", d, 8'h10);
    chk("R11 irq set", {7'd0, done_irq}, 8'h01);

    // R11 sticky flag
    repeat (6) @(negedge clk);
    chk("R11 flag holds", {7'd0, done_irq}, 8'h01);
    bw(2'd2, 8'h14); br(2'd2, d); chk("R11 write one keeps", d, 8'h14);
    bw(2'd2, 8'h04); br(2'd2, d); chk("R11 clear", d, 8'h04);
    chk("R11 irq cleared", {7'd0, done_irq}, 8'h00);
    readback(6'd10, "R9 write landed");
    readback(6'd20, "R9 other addr untouched");

    // R10 hardware never clears enable
    repeat (10) @(negedge clk);
    br(2'd2, d); chk("R10 enable kept", d, 8'h04);

    // R4 hold and R3 mem-select read
    readback(6'd3, "R3 read");
    bw(2'd0, 8'd4); br(2'd2, d); bw(2'd3, 8'h55);
    br(2'd1, d); chk("R4 holds", d, model[3]);
    bw(2'd2, 8'h81); br(2'd1, d); chk("R3 msel no load", d, model[3]);
    br(2'd2, d); chk("R3 rd reads zero", d, 8'h80);
    bw(2'd1, 8'h5A); br(2'd1, d); chk("R4 cpu overwrite", d, 8'h5A);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule